// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Controller

This block gathers 32 interrupt requests into one CPU interrupt line. Each request position is fixed at elaboration as either edge-sensitive or level-sensitive. Level positions show the live, registered input in the status word. Edge positions latch a rising transition into a sticky hard-interrupt register. Software clears a latched edge by writing that register back with the bit at zero.

Three status positions (4, 5 and 6) are not fed from the direct request inputs. They carry the group summaries of a cascaded peripheral sub-controller. Positions 28 to 30 can also be raised from software through a soft-request register. The status word is masked, and the result drives the CPU line. It also drives a pending-valid flag and the index of the lowest set bit, so a lower index wins. Software reaches the mask, hard, soft and status registers through a small register port with one cycle of read latency.

Top module: `mixirq_ctrl`

## Requirements
- R1: After reset, mask, hard and soft registers read zero, and `irq_o` and `pend_vld_o` are low.
- R2: A level position's status bit follows its input: `irq_o` and the index change on the second rising clock edge after the input changes, and they drop again when the input drops.
- R3: A rising edge on an edge-typed position (16–19, 22–24, 28–31) sets its hard bit, which stays set after the input falls. A steady high input sets it only once.
- R4: A write to address 1 (hard) clears every hard bit written as 0 and leaves every bit written as 1 unchanged. A write never sets a hard bit.
- R5: If a new rising edge and a clearing write hit the same hard bit in one cycle, the bit ends up set.
- R6: `irq_o` is high exactly when status AND mask is nonzero, registered one cycle after that value.
- R7: `pend_idx_o` gives the lowest-numbered set bit of status AND mask, and `pend_vld_o` is low with index 0 when nothing is pending.
- R8: Status bits 4, 5 and 6 come from `casc_i[0]`, `casc_i[1]` and `casc_i[2]`; `src_i[6:4]` is ignored.
- R9: The soft register at address 2 keeps only bits 28–30; other written bits read back 0. Its bits OR into status.
- R10: Register map: address 0 mask, 1 hard, 2 soft, 3 status (read-only, writes ignored); `rdata_o` returns the addressed register one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Direct interrupt requests |
| casc_i | input | 3 | Group summaries of the cascaded sub-controller |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | CPU interrupt line |
| pend_vld_o | output | 1 | Something is pending |
| pend_idx_o | output | 5 | Lowest pending position |

## Verification
A new rising edge and a software clear of the same hard bit can land in one clock cycle. The bench provokes this by latching position 19, then raising that input on the same falling edge where it presents a write that clears bit 19. It judges the result by reading the hard register back, which must still show bit 19. A later clear while the input stays high must then leave the bit at zero.

// File: rtl/mixirq_pkg.sv
package mixirq_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MASK = 2'd0,
    REG_HARD = 2'd1,
    REG_SOFT = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mixirq_input.sv
module mixirq_input #(
  parameter int unsigned NSRC      = 32,
  parameter int unsigned NCASC     = 3,
  parameter int unsigned CASC_LSB  = 4,
  parameter logic [NSRC-1:0] EDGE_MASK = 32'hF1CF_0000
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [NSRC-1:0] src_i,
  input  logic [NCASC-1:0] casc_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_data_i,
  output logic [NSRC-1:0] src_q_o,
  output logic [NSRC-1:0] hard_q_o,
  output logic [NSRC-1:0] rise_o
);
  logic [NSRC-1:0] src_eff;
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] hard_q;
  logic [NSRC-1:0] hard_d;

  // cascade summaries replace the direct inputs at their positions
  for (genvar i = 0; i < NSRC; i++) begin : g_sel
    if (i >= CASC_LSB && i < CASC_LSB + NCASC) begin : g_casc
      assign src_eff[i] = casc_i[i-CASC_LSB];
    end else begin : g_direct
      assign src_eff[i] = src_i[i];
    end
  end

  assign rise_o = src_eff & ~src_q & EDGE_MASK;

  always_comb begin
    hard_d = hard_q;
    if (clr_we_i) hard_d = hard_q & clr_data_i;
    hard_d = hard_d | rise_o;   // a fresh edge outranks a clear
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      src_q  <= '0;
      hard_q <= '0;
    end else begin
      src_q  <= src_eff;
      hard_q <= hard_d;
    end
  end

  assign src_q_o  = src_q;
  assign hard_q_o = hard_q;
endmodule

// File: rtl/mixirq_regs.sv
module mixirq_regs
  import mixirq_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter logic [NSRC-1:0] SOFT_MASK = 32'h7000_0000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NSRC-1:0]   wdata_i,
  input  logic [NSRC-1:0]   hard_q_i,
  input  logic [NSRC-1:0]   status_i,
  output logic [NSRC-1:0]   mask_q_o,
  output logic [NSRC-1:0]   soft_q_o,
  output logic              hard_we_o,
  output logic [NSRC-1:0]   rdata_o
);
  reg_sel_e        sel;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] soft_q;
  logic [NSRC-1:0] rd_d;

  assign sel       = reg_sel_e'(addr_i);
  assign hard_we_o = we_i && (sel == REG_HARD);

  always_comb begin
    unique case (sel)
      REG_MASK: rd_d = mask_q;
      REG_HARD: rd_d = hard_q_i;
      REG_SOFT: rd_d = soft_q;
      default:  rd_d = status_i;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mask_q  <= '0;
      soft_q  <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i && sel == REG_MASK) mask_q <= wdata_i;
      if (we_i && sel == REG_SOFT) soft_q <= wdata_i & SOFT_MASK;
      rdata_o <= rd_d;
    end
  end

  assign mask_q_o = mask_q;
  assign soft_q_o = soft_q;
endmodule

// File: rtl/mixirq_prio.sv
module mixirq_prio #(
  parameter int unsigned NSRC  = 32,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  act_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mixirq_ctrl.sv
module mixirq_ctrl
  import mixirq_pkg::*;
#(
  parameter int unsigned NSRC     = 32,
  parameter int unsigned NCASC    = 3,
  parameter int unsigned CASC_LSB = 4,
  parameter logic [NSRC-1:0] EDGE_MASK = 32'hF1CF_0000,
  parameter logic [NSRC-1:0] SOFT_MASK = 32'h7000_0000,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NSRC-1:0]   src_i,
  input  logic [NCASC-1:0]  casc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic              irq_o,
  output logic              pend_vld_o,
  output logic [IDX_W-1:0]  pend_idx_o
);
  logic [NSRC-1:0]  src_q;
  logic [NSRC-1:0]  hard_q;
  logic [NSRC-1:0]  rise_w;
  logic [NSRC-1:0]  mask_q;
  logic [NSRC-1:0]  soft_q;
  logic             hard_we;
  logic [NSRC-1:0]  status_w;
  logic [NSRC-1:0]  act_w;
  logic             enc_vld;
  logic [IDX_W-1:0] enc_idx;

  mixirq_input #(
    .NSRC(NSRC), .NCASC(NCASC), .CASC_LSB(CASC_LSB), .EDGE_MASK(EDGE_MASK)
  ) u_input (
    .clk_i(clk_i), .rst_i(rst_i), .src_i(src_i), .casc_i(casc_i),
    .clr_we_i(hard_we), .clr_data_i(wdata_i),
    .src_q_o(src_q), .hard_q_o(hard_q), .rise_o(rise_w)
  );

  assign status_w = (src_q & ~EDGE_MASK) | hard_q | soft_q;
  assign act_w    = status_w & mask_q;

  mixirq_regs #(.NSRC(NSRC), .SOFT_MASK(SOFT_MASK)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .hard_q_i(hard_q), .status_i(status_w),
    .mask_q_o(mask_q), .soft_q_o(soft_q), .hard_we_o(hard_we),
    .rdata_o(rdata_o)
  );

  mixirq_prio #(.NSRC(NSRC)) u_prio (
    .act_i(act_w), .vld_o(enc_vld), .idx_o(enc_idx)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_o      <= 1'b0;
      pend_vld_o <= 1'b0;
      pend_idx_o <= '0;
    end else begin
      irq_o      <= |act_w;
      pend_vld_o <= enc_vld;
      pend_idx_o <= enc_idx;
    end
  end
endmodule

// File: rtl/mixirq_ctrl_chk.sv
module mixirq_ctrl_chk #(
  parameter int unsigned NSRC = 32,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [NSRC-1:0]  hard_q,
  input logic [NSRC-1:0]  rise_w,
  input logic [NSRC-1:0]  act_w,
  input logic             irq_o,
  input logic             pend_vld_o,
  input logic [IDX_W-1:0] pend_idx_o
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (!irq_o && !pend_vld_o && hard_q == '0));

  // R6
  a_r6_line_matches_valid: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o == pend_vld_o);

  // R7
  a_r7_index_is_pending: assert property (@(posedge clk_i) disable iff (rst_i)
    pend_vld_o |-> (($past(act_w) & (NSRC'(1) << pend_idx_o)) != '0));

  // R7
  a_r7_index_is_lowest: assert property (@(posedge clk_i) disable iff (rst_i)
    pend_vld_o |-> (($past(act_w) & ((NSRC'(1) << pend_idx_o) - NSRC'(1))) == '0));

  // R5
  a_r5_edge_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    (|rise_w) |=> ((hard_q & $past(rise_w)) == $past(rise_w)));

  // R4
  a_r4_write_never_sets: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && addr_i == 2'd1) |=> ((hard_q & ~($past(hard_q) | $past(rise_w))) == '0));
endmodule

bind mixirq_ctrl mixirq_ctrl_chk #(.NSRC(NSRC)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .we_i(we_i), .addr_i(addr_i),
  .hard_q(hard_q), .rise_w(rise_w), .act_w(act_w),
  .irq_o(irq_o), .pend_vld_o(pend_vld_o), .pend_idx_o(pend_idx_o)
);

// File: tb/mixirq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mixirq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic [2:0]  casc = '0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        vld;
  logic [4:0]  idx;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mixirq_ctrl dut_i (
    .clk_i(clk), .rst_i(rst), .src_i(src), .casc_i(casc), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .pend_vld_o(vld), .pend_idx_o(idx)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [2:0]  casc;
    logic [31:0] mask;
    logic        exp_irq;
    logic [4:0]  exp_idx;
  } vec_t;

  // level positions only; R2, R6, R7 and R8 cases
  localparam vec_t VECS [7] = '{
    '{32'h0000_0001, 3'b000, 32'hFFFF_FFFF, 1'b1, 5'd0},
    '{32'h0000_0300, 3'b000, 32'hFFFF_FFFF, 1'b1, 5'd8},
    '{32'h0800_0300, 3'b000, 32'h0800_0000, 1'b1, 5'd27},
    '{32'h0000_0070, 3'b000, 32'hFFFF_FFFF, 1'b0, 5'd0},
    '{32'h0000_0000, 3'b100, 32'hFFFF_FFFF, 1'b1, 5'd6},
    '{32'h0020_0000, 3'b010, 32'hFFFF_FFFF, 1'b1, 5'd5},
    '{32'h0000_8000, 3'h0,   32'h0000_7FFF, 1'b0, 5'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 vld", {31'b0, vld}, 32'd0);
    rd(2'd0, r); chk("R1 mask", r, 32'h0);
    rd(2'd1, r); chk("R1 hard", r, 32'h0);
    rd(2'd2, r); chk("R1 soft", r, 32'h0);

    // table walk: R2 R6 R7 R8
    for (int k = 0; k < 7; k++) begin
      wr(2'd0, VECS[k].mask);
      @(negedge clk);
      src = VECS[k].src; casc = VECS[k].casc;
      settle();
      chk($sformatf("R6 vec%0d irq", k), {31'b0, irq}, {31'b0, VECS[k].exp_irq});
      chk($sformatf("R7 vec%0d vld", k), {31'b0, vld}, {31'b0, VECS[k].exp_irq});
      chk($sformatf("R8 vec%0d idx", k), {27'b0, idx}, {27'b0, VECS[k].exp_idx});
    end
    // R2 level drop clears the line
    wr(2'd0, 32'hFFFF_FFFF);
    @(negedge clk); src = 32'h0000_0004; casc = '0;
    settle(); chk("R2 level high idx", {27'b0, idx}, 32'd2);
    @(negedge clk); src = '0;
    settle(); chk("R2 level low irq", {31'b0, irq}, 32'd0);

    // R3 edge latch stays after input falls
    wr(2'd0, 32'h0001_0000);
    @(negedge clk); src[16] = 1'b1; src[17] = 1'b1;
    @(negedge clk); src[16] = 1'b0; src[17] = 1'b0;
    settle();
    rd(2'd1, r); chk("R3 hard latched", r, 32'h0003_0000);
    chk("R3 irq idx", {26'b0, irq, idx}, {26'b0, 1'b1, 5'd16});

    // R4 clear only zero-written bits, ones never set
    wr(2'd1, ~32'h0001_0000);
    rd(2'd1, r); chk("R4 clear one bit", r, 32'h0002_0000);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, r); chk("R4 ones no set", r, 32'h0002_0000);
    settle(); chk("R4 irq after clear", {31'b0, irq}, 32'd0);
    wr(2'd1, 32'h0);

    // R5 edge and clear in the same cycle
    @(negedge clk); src[19] = 1'b1;
    @(negedge clk); src[19] = 1'b0;
    @(negedge clk);
    src[19] = 1'b1; we = 1'b1; addr = 2'd1; wdata = ~32'h0008_0000;
    @(negedge clk); we = 1'b0;
    rd(2'd1, r); chk("R5 edge wins", r, 32'h0008_0000);
    // R3 steady high does not relatch
    wr(2'd1, ~32'h0008_0000);
    settle();
    rd(2'd1, r); chk("R3 no relatch", r, 32'h0);
    @(negedge clk); src[19] = 1'b0;

    // R9 soft register bits
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, r); chk("R9 soft readback", r, 32'h7000_0000);
    rd(2'd3, r); chk("R9 soft in status", r, 32'h7000_0000);
    wr(2'd0, 32'h2000_0000);
    settle(); chk("R9 soft idx", {26'b0, irq, idx}, {26'b0, 1'b1, 5'd29});

    // R10 status read-only, map
    wr(2'd3, 32'h0000_0000);
    rd(2'd3, r); chk("R10 status write ignored", r, 32'h7000_0000);
    rd(2'd0, r); chk("R10 mask map", r, 32'h2000_0000);
    wr(2'd2, 32'h0);
    settle();
    chk("R7 nothing pending", {26'b0, vld, idx}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule